// File: doc/BRIEF.md
# Deferred Floating-Point Exception Queue

This block keeps an ordered record of the floating-point operations that have been issued to the arithmetic units but have not finished yet. Each issue stores the operation's address and its 32-bit instruction word in a free slot. The slot number goes back to the issuer as a tag. A unit that finishes an operation returns that tag. If the operation finished normally, the slot is marked done. Done slots at the old end of the record are released in issue order.

When a unit reports an arithmetic exception, the block freezes. The exception is not raised on the operation that caused it. The block takes exactly one more issue, and raises a trap request on the cycle after that later issue, so the trap lands on that later operation. From then on the block refuses issues until a supervisor-mode handler has drained it.

Each read request from the handler removes one entry and returns it as two words on consecutive cycles: the address first, then the instruction word. The first read returns the faulting operation. Later reads return the operations that are still unfinished, oldest first, and the last of these is the operation on which the trap was raised. An empty flag tells the handler when to stop reading. Once the block has been drained it clears itself and takes issues again.

Top module: `fp_defer_queue`

## Requirements
- R1: After synchronous reset, `q_empty` is 1, `disp_ready` is 1, `trap_req`, `rd_valid`, `rd_priv_err` and `rd_underflow` are 0, and `disp_tag` is 0.
- R2: With no exception recorded, an issue is accepted in any cycle where `disp_valid` and `disp_ready` are both 1. `disp_ready` is 0 exactly when DEPTH accepted entries have not yet been released. `disp_tag` shows the tag of the next accepted issue and changes only when an issue is accepted.
- R3: A normal completion (`cmp_valid`=1, `cmp_exc`=0, `cmp_tag` = the entry's tag) marks the entry done. Entries are released strictly in issue order, one per cycle, starting in the cycle after the oldest entry is done. A younger entry that is done does not free any capacity while an older entry is unfinished.
- R4: A completion with `cmp_exc`=1 on an unfinished entry records an exception. After that the block accepts exactly one further issue, pulses `trap_req` for one cycle in the cycle after that issue is accepted, and then keeps `disp_ready` at 0 until the record has been drained.
- R5: `trap_req` stays 0 between the exception and the next accepted issue, however long that gap is.
- R6: A read is requested by `rd_req`=1 with `rd_super`=1. The first read after an exception returns the faulting entry. `rd_valid` is 1 for two consecutive cycles starting the cycle after the request, with `rd_data` carrying the address in the first cycle and the instruction word in the second.
- R7: Each following read returns the oldest entry that is still unfinished, skipping entries that completed normally. The last entry returned is the issue that raised the trap.
- R8: `q_empty` is 1 exactly when no stored entry is unfinished. Once a frozen block has been read until `q_empty` is 1 and its last transfer has ended, it leaves the frozen state, and `disp_ready` returns to 1.
- R9: A request with `rd_super`=0 removes nothing, gives no `rd_valid`, and pulses `rd_priv_err` for one cycle.
- R10: A supervisor request while `q_empty`=1 gives no `rd_valid` and pulses `rd_underflow` for one cycle.
- R11: Requests made while a two-word transfer is in progress are ignored. A request held high for three cycles removes exactly one entry.
- R12: There are DEPTH+1 slots. Tags are handed out cyclically as 0, 1, …, DEPTH, then 0 again, and a freeze-and-drain does not reset the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Issue request |
| disp_addr | input | WORD_W | Address of the issued operation |
| disp_insn | input | WORD_W | Instruction word of the issued operation |
| disp_ready | output | 1 | Issue can be accepted this cycle |
| disp_tag | output | TAG_W | Tag given to the next accepted issue |
| cmp_valid | input | 1 | A unit finished an operation |
| cmp_tag | input | TAG_W | Tag of the finished operation |
| cmp_exc | input | 1 | The finished operation raised an exception |
| trap_req | output | 1 | One-cycle trap request, raised after a later issue |
| rd_req | input | 1 | Handler read request |
| rd_super | input | 1 | Requester is in supervisor state |
| rd_valid | output | 1 | `rd_data` carries a word |
| rd_data | output | WORD_W | Address word, then instruction word |
| q_empty | output | 1 | No unfinished entry remains |
| rd_priv_err | output | 1 | Read refused because the requester is not in supervisor state |
| rd_underflow | output | 1 | Read refused because nothing was left to read |

## Verification
The hardest state to reach is a frozen record in which the order of delivery differs from the order of issue. To reach it, the faulting entry must be the oldest, an entry that completed normally must sit behind it, and the issue that raises the trap must come after a long quiet gap. The stimulus builds this with three issues. It completes the youngest one normally, then reports an exception on the oldest. It waits several idle cycles before the trapping issue, and it tries one more issue that must be refused. The drain then runs with a refused non-supervisor read and a request held across a whole transfer. A final read on the empty record checks the underflow pulse.

// File: rtl/fpdq_pkg.sv
package fpdq_pkg;
  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_ADDR = 2'd1,
    RD_INSN = 2'd2
  } rd_state_e;
endpackage

// File: rtl/fpdq_store.sv
module fpdq_store #(
  parameter int SLOTS  = 5,
  parameter int TAG_W  = 3,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [TAG_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata_a,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              re_a,
  input  logic [TAG_W-1:0]  raddr_a,
  input  logic              re_i,
  input  logic [TAG_W-1:0]  raddr_i,
  output logic [WORD_W-1:0] rdata_a,
  output logic [WORD_W-1:0] rdata_i
);
  // Two simple dual-port arrays with registered reads (block RAM friendly)
  logic [WORD_W-1:0] addr_mem [SLOTS];
  logic [WORD_W-1:0] insn_mem [SLOTS];

  always_ff @(posedge clk) begin
    if (we) begin
      addr_mem[waddr] <= wdata_a;
      insn_mem[waddr] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (re_a) rdata_a <= addr_mem[raddr_a];
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_i <= insn_mem[raddr_i];
  end
endmodule

// File: rtl/fpdq_pick.sv
module fpdq_pick #(
  parameter int SLOTS = 5,
  parameter int TAG_W = 3
) (
  input  logic [SLOTS-1:0] live,
  input  logic [TAG_W-1:0] head,
  input  logic [TAG_W-1:0] fault_idx,
  input  logic             fault_live,
  output logic [TAG_W-1:0] sel
);
  // The faulting entry wins; otherwise the oldest unfinished entry from head.
  always_comb begin
    sel = head;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      int j;
      j = int'(head) + i;
      if (j >= SLOTS) j = j - SLOTS;
      if (live[j]) sel = TAG_W'(j);
    end
    if (fault_live && live[fault_idx]) sel = fault_idx;
  end
endmodule

// File: rtl/fpdq_track.sv
module fpdq_track #(
  parameter int DEPTH = 4,
  parameter int SLOTS = 5,
  parameter int TAG_W = 3,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             disp_valid,
  input  logic             cmp_valid,
  input  logic [TAG_W-1:0] cmp_tag,
  input  logic             cmp_exc,
  input  logic             pop_fire,
  input  logic [TAG_W-1:0] pop_idx,
  input  logic             rd_idle,
  output logic             disp_fire,
  output logic             disp_ready,
  output logic [TAG_W-1:0] tail,
  output logic [TAG_W-1:0] head,
  output logic [SLOTS-1:0] live,
  output logic             q_empty,
  output logic             trap_req,
  output logic [TAG_W-1:0] fault_idx,
  output logic             fault_live
);
  logic [SLOTS-1:0] valid_q, pend_q, valid_n, pend_n;
  logic [TAG_W-1:0] head_q, tail_q, fault_q;
  logic [CNT_W-1:0] cnt_q;
  logic frozen_q, armed_q, flive_q, trap_q;
  logic cmp_hit, exc_new, retire, thaw;

  function automatic logic [TAG_W-1:0] step(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign live       = valid_q & pend_q;
  assign q_empty    = ~|live;
  assign disp_ready = frozen_q ? armed_q : (cnt_q < CNT_W'(DEPTH));
  assign disp_fire  = disp_valid & disp_ready;
  assign cmp_hit    = cmp_valid && (int'(cmp_tag) < SLOTS) && live[cmp_tag];
  assign exc_new    = cmp_hit && cmp_exc && !frozen_q;
  assign retire     = !frozen_q && (cnt_q != '0) && !live[head_q];
  assign thaw       = frozen_q && q_empty && rd_idle && !disp_fire;

  always_comb begin
    valid_n = valid_q;
    pend_n  = pend_q;
    if (cmp_hit && !cmp_exc) pend_n[cmp_tag] = 1'b0;
    if (pop_fire)            valid_n[pop_idx] = 1'b0;
    if (retire)              valid_n[head_q] = 1'b0;
    if (disp_fire) begin
      valid_n[tail_q] = 1'b1;
      pend_n[tail_q]  = 1'b1;
    end
    if (thaw) valid_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      pend_q   <= '0;
      head_q   <= '0;
      tail_q   <= '0;
      cnt_q    <= '0;
      frozen_q <= 1'b0;
      armed_q  <= 1'b0;
      flive_q  <= 1'b0;
      fault_q  <= '0;
      trap_q   <= 1'b0;
    end else begin
      valid_q <= valid_n;
      pend_q  <= pend_n;
      trap_q  <= frozen_q && armed_q && disp_fire;
      if (disp_fire) tail_q <= step(tail_q);
      if (thaw) begin
        head_q   <= tail_q;
        cnt_q    <= '0;
        frozen_q <= 1'b0;
        armed_q  <= 1'b0;
        flive_q  <= 1'b0;
      end else begin
        if (retire) head_q <= step(head_q);
        cnt_q <= cnt_q + CNT_W'(disp_fire) - CNT_W'(retire);
        if (exc_new) begin
          frozen_q <= 1'b1;
          armed_q  <= 1'b1;
          fault_q  <= cmp_tag;
          flive_q  <= 1'b1;
        end else begin
          if (armed_q && disp_fire) armed_q <= 1'b0;
          if (pop_fire && pop_idx == fault_q) flive_q <= 1'b0;
        end
      end
    end
  end

  assign tail       = tail_q;
  assign head       = head_q;
  assign trap_req   = trap_q;
  assign fault_idx  = fault_q;
  assign fault_live = flive_q;
endmodule

// File: rtl/fpdq_reader.sv
module fpdq_reader
  import fpdq_pkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              rd_super,
  input  logic              q_empty,
  input  logic [TAG_W-1:0]  sel_idx,
  input  logic [WORD_W-1:0] mem_a,
  input  logic [WORD_W-1:0] mem_i,
  output logic              pop_fire,
  output logic [TAG_W-1:0]  pop_idx,
  output logic              re_a,
  output logic [TAG_W-1:0]  raddr_a,
  output logic              re_i,
  output logic [TAG_W-1:0]  raddr_i,
  output logic              rd_idle,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              priv_err,
  output logic              underflow
);
  rd_state_e        state_q;
  logic [TAG_W-1:0] idx_q;

  assign rd_idle  = (state_q == RD_IDLE);
  assign pop_fire = rd_idle && rd_req && rd_super && !q_empty;
  assign pop_idx  = sel_idx;
  assign re_a     = pop_fire;
  assign raddr_a  = sel_idx;
  assign re_i     = (state_q == RD_ADDR);
  assign raddr_i  = idx_q;
  assign rd_valid = !rd_idle;
  assign rd_data  = (state_q == RD_INSN) ? mem_i : mem_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= RD_IDLE;
      idx_q     <= '0;
      priv_err  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      priv_err  <= rd_idle && rd_req && !rd_super;
      underflow <= rd_idle && rd_req && rd_super && q_empty;
      unique case (state_q)
        RD_IDLE: if (pop_fire) begin
          state_q <= RD_ADDR;
          idx_q   <= sel_idx;
        end
        RD_ADDR: state_q <= RD_INSN;
        RD_INSN: state_q <= RD_IDLE;
        default: state_q <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fp_defer_queue.sv
module fp_defer_queue #(
  parameter int DEPTH  = 4,
  parameter int WORD_W = 32,
  parameter int TAG_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              disp_valid,
  input  logic [WORD_W-1:0] disp_addr,
  input  logic [WORD_W-1:0] disp_insn,
  output logic              disp_ready,
  output logic [TAG_W-1:0]  disp_tag,
  input  logic              cmp_valid,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic              cmp_exc,
  output logic              trap_req,
  input  logic              rd_req,
  input  logic              rd_super,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              q_empty,
  output logic              rd_priv_err,
  output logic              rd_underflow
);
  localparam int SLOTS = DEPTH + 1;
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic             disp_fire, pop_fire, rd_idle, fault_live, re_a, re_i;
  logic [TAG_W-1:0] tail, head, fault_idx, sel_idx, pop_idx, raddr_a, raddr_i;
  logic [SLOTS-1:0] live;
  logic [WORD_W-1:0] mem_a, mem_i;

  fpdq_track #(.DEPTH(DEPTH), .SLOTS(SLOTS), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_track (
    .clk(clk), .rst(rst), .disp_valid(disp_valid),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_exc(cmp_exc),
    .pop_fire(pop_fire), .pop_idx(pop_idx), .rd_idle(rd_idle),
    .disp_fire(disp_fire), .disp_ready(disp_ready), .tail(tail), .head(head),
    .live(live), .q_empty(q_empty), .trap_req(trap_req),
    .fault_idx(fault_idx), .fault_live(fault_live)
  );

  fpdq_pick #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_pick (
    .live(live), .head(head), .fault_idx(fault_idx),
    .fault_live(fault_live), .sel(sel_idx)
  );

  fpdq_store #(.SLOTS(SLOTS), .TAG_W(TAG_W), .WORD_W(WORD_W)) u_store (
    .clk(clk), .we(disp_fire), .waddr(tail),
    .wdata_a(disp_addr), .wdata_i(disp_insn),
    .re_a(re_a), .raddr_a(raddr_a), .re_i(re_i), .raddr_i(raddr_i),
    .rdata_a(mem_a), .rdata_i(mem_i)
  );

  fpdq_reader #(.TAG_W(TAG_W), .WORD_W(WORD_W)) u_reader (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_super(rd_super),
    .q_empty(q_empty), .sel_idx(sel_idx), .mem_a(mem_a), .mem_i(mem_i),
    .pop_fire(pop_fire), .pop_idx(pop_idx), .re_a(re_a), .raddr_a(raddr_a),
    .re_i(re_i), .raddr_i(raddr_i), .rd_idle(rd_idle), .rd_valid(rd_valid),
    .rd_data(rd_data), .priv_err(rd_priv_err), .underflow(rd_underflow)
  );

  assign disp_tag = tail;
endmodule

// File: rtl/fpdq_chk.sv
module fpdq_chk #(
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             disp_valid,
  input logic             disp_ready,
  input logic [TAG_W-1:0] disp_tag,
  input logic             trap_req,
  input logic             rd_valid,
  input logic             q_empty,
  input logic             rd_priv_err,
  input logic             rd_underflow
);
  AST_TRAP_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> $past(disp_valid && disp_ready));                       // R4
  AST_TRAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> !trap_req);                                             // R4
  AST_TRAP_HAS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> !q_empty);                                              // R5
  AST_TAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(disp_valid && disp_ready) |=> $stable(disp_tag));                  // R2
  AST_PAIR_SECOND: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |=> rd_valid);                                       // R6
  AST_PAIR_END: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_valid)) |=> !rd_valid);                        // R11
  AST_PRIV_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    rd_priv_err |-> !rd_valid);                                          // R9
  AST_UNDERFLOW_EMPTY: assert property (@(posedge clk) disable iff (rst)
    rd_underflow |-> (!rd_valid && $past(q_empty)));                     // R10
endmodule

bind fp_defer_queue fpdq_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_tag(disp_tag), .trap_req(trap_req), .rd_valid(rd_valid),
  .q_empty(q_empty), .rd_priv_err(rd_priv_err), .rd_underflow(rd_underflow)
);

// File: tb/fp_defer_queue_tb.sv
module fp_defer_queue_tb;
  localparam int DEPTH = 4;
  localparam int SLOTS = DEPTH + 1;
  localparam int TW    = $clog2(SLOTS);

  logic clk = 1'b0, rst = 1'b1;
  logic disp_valid = 0, cmp_valid = 0, cmp_exc = 0, rd_req = 0, rd_super = 0;
  logic [31:0] disp_addr = '0, disp_insn = '0;
  logic [TW-1:0] cmp_tag = '0;
  logic disp_ready, trap_req, rd_valid, q_empty, rd_priv_err, rd_underflow;
  logic [TW-1:0] disp_tag;
  logic [31:0] rd_data;

  always #10 clk = ~clk;

  fp_defer_queue #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_addr(disp_addr),
    .disp_insn(disp_insn), .disp_ready(disp_ready), .disp_tag(disp_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_exc(cmp_exc),
    .trap_req(trap_req), .rd_req(rd_req), .rd_super(rd_super),
    .rd_valid(rd_valid), .rd_data(rd_data), .q_empty(q_empty),
    .rd_priv_err(rd_priv_err), .rd_underflow(rd_underflow)
  );

  int checks = 0, fails = 0;
  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct {
    logic [TW-1:0] tag;
    logic [31:0]   a;
    logic [31:0]   w;
    bit            pend;
    bit            live;
  } ent_t;
  ent_t mq[$];
  bit m_frozen, m_armed, m_flive, m_trap, m_priv, m_under;
  logic [TW-1:0] m_ftag, m_tail;
  int m_phase;
  logic [31:0] m_w0, m_w1;
  bit fire, e_pre, retire, thaw, n_priv, n_under, exc_new;
  int popk;

  function automatic bit m_ready();
    return m_frozen ? m_armed : (mq.size() < DEPTH);
  endfunction
  function automatic bit m_empty();
    foreach (mq[k]) if (mq[k].live && mq[k].pend) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      m_frozen = 0; m_armed = 0; m_flive = 0; m_trap = 0; m_priv = 0; m_under = 0;
      m_ftag = '0; m_tail = '0; m_phase = 0; m_w0 = '0; m_w1 = '0;
    end else begin
      fire    = disp_valid && m_ready();
      e_pre   = m_empty();
      retire  = !m_frozen && mq.size() > 0 && !(mq[0].live && mq[0].pend);
      thaw    = m_frozen && e_pre && m_phase == 0 && !fire;
      n_priv  = 0; n_under = 0; popk = -1; exc_new = 0;
      if (m_phase == 0 && rd_req) begin
        if (!rd_super) n_priv = 1;
        else if (e_pre) n_under = 1;
        else begin
          if (m_flive)
            foreach (mq[k]) if (mq[k].tag == m_ftag && mq[k].live && mq[k].pend) popk = k;
          if (popk < 0)
            for (int k = 0; k < mq.size(); k++)
              if (mq[k].live && mq[k].pend) begin popk = k; break; end
        end
      end
      if (cmp_valid)
        foreach (mq[k])
          if (mq[k].tag == cmp_tag && mq[k].live && mq[k].pend) begin
            if (!cmp_exc) mq[k].pend = 0;
            else if (!m_frozen) exc_new = 1;
          end
      if (popk >= 0) begin
        m_w0 = mq[popk].a; m_w1 = mq[popk].w; mq[popk].live = 0;
        if (m_flive && mq[popk].tag == m_ftag) m_flive = 0;
        m_phase = 1;
      end else if (m_phase == 1) m_phase = 2;
      else if (m_phase == 2) m_phase = 0;
      m_priv = n_priv; m_under = n_under;
      m_trap = m_frozen && m_armed && fire;
      if (retire) void'(mq.pop_front());
      if (fire) begin
        mq.push_back('{m_tail, disp_addr, disp_insn, 1'b1, 1'b1});
        m_tail = (m_tail == TW'(SLOTS - 1)) ? '0 : m_tail + 1'b1;
      end
      if (exc_new) begin
        m_frozen = 1; m_armed = 1; m_ftag = cmp_tag; m_flive = 1;
      end else if (m_armed && fire) m_armed = 0;
      if (thaw) begin
        mq.delete(); m_frozen = 0; m_armed = 0; m_flive = 0;
      end
    end
  end

  // ---------------- per-cycle comparison and capture ----------------
  logic [31:0] cap[$];
  bit seen_priv = 0, seen_under = 0;
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 disp_ready", 32'(disp_ready), 32'(m_ready()));
      chk("R2 disp_tag", 32'(disp_tag), 32'(m_tail));
      chk("R8 q_empty", 32'(q_empty), 32'(m_empty()));
      chk("R5 trap_req", 32'(trap_req), 32'(m_trap));
      chk("R6 rd_valid", 32'(rd_valid), 32'(m_phase != 0));
      if (m_phase != 0) chk("R7 rd_data", rd_data, (m_phase == 1) ? m_w0 : m_w1);
      chk("R9 rd_priv_err", 32'(rd_priv_err), 32'(m_priv));
      chk("R10 rd_underflow", 32'(rd_underflow), 32'(m_under));
      if (rd_valid) cap.push_back(rd_data);
      if (rd_priv_err) seen_priv = 1;
      if (rd_underflow) seen_under = 1;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic issue(input logic [31:0] a, input logic [31:0] w);
    @(negedge clk); disp_valid = 1; disp_addr = a; disp_insn = w;
    @(negedge clk); disp_valid = 0;
  endtask
  task automatic finish_op(input int t, input bit exc);
    @(negedge clk); cmp_valid = 1; cmp_tag = TW'(t); cmp_exc = exc;
    @(negedge clk); cmp_valid = 0; cmp_exc = 0;
  endtask
  task automatic rd(input bit sup, input int hold);
    @(negedge clk); rd_req = 1; rd_super = sup;
    repeat (hold - 1) @(negedge clk);
    @(negedge clk); rd_req = 0; rd_super = 0;
  endtask
  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 q_empty", 32'(q_empty), 1);
    chk("R1 disp_ready", 32'(disp_ready), 1);
    chk("R1 rd_valid", 32'(rd_valid), 0);
    chk("R1 trap_req", 32'(trap_req), 0);
    chk("R1 disp_tag", 32'(disp_tag), 0);

    // R2 fill to DEPTH
    for (int i = 0; i < DEPTH; i++) issue(32'h1000 + 32'(4 * i), 32'hA000_0000 + 32'(i));
    idle(1);
    chk("R2 full stalls", 32'(disp_ready), 0);
    // R3 younger done, older pending: no capacity freed
    finish_op(3, 0); idle(2);
    chk("R3 in-order hold", 32'(disp_ready), 0);
    finish_op(0, 0); idle(2);
    chk("R3 oldest retires", 32'(disp_ready), 1);
    finish_op(1, 0); finish_op(2, 0); idle(3);
    chk("R3 all released", 32'(q_empty), 1);
    // R12 tag wrap
    chk("R12 tag DEPTH", 32'(disp_tag), DEPTH);
    issue(32'h1100, 32'hA000_0010);
    chk("R12 tag wraps", 32'(disp_tag), 0);
    finish_op(DEPTH, 0); idle(2);

    // exception scenario: A=tag0, B=tag1, D=tag2
    issue(32'h2000, 32'hC000_000A);
    issue(32'h2004, 32'hC000_000B);
    issue(32'h2008, 32'hC000_000D);
    finish_op(2, 0);
    finish_op(0, 1);
    idle(4);
    chk("R5 no trap on faulting op", 32'(trap_req), 0);
    chk("R4 one more issue allowed", 32'(disp_ready), 1);
    issue(32'h200C, 32'hC000_000C);   // C, tag3
    chk("R4 trap after later issue", 32'(trap_req), 1);
    idle(1);
    chk("R4 trap one cycle", 32'(trap_req), 0);
    chk("R4 issues refused", 32'(disp_ready), 0);
    issue(32'h2010, 32'hC000_000E);
    chk("R4 refused issue takes no tag", 32'(disp_tag), 4);

    // R9 non-supervisor read
    rd(0, 1); idle(3);
    chk("R9 no data", 32'(cap.size()), 0);
    chk("R9 pulse seen", 32'(seen_priv), 1);
    chk("R9 nothing removed", 32'(q_empty), 0);
    // R6 faulting entry first
    rd(1, 1); idle(3);
    chk("R6 two words", 32'(cap.size()), 2);
    if (cap.size() == 2) begin
      chk("R6 address word", cap[0], 32'h2000);
      chk("R6 instruction word", cap[1], 32'hC000_000A);
    end
    cap.delete();
    // R11 held request gives one transfer; R7 oldest unfinished next
    rd(1, 3); idle(3);
    chk("R11 single transfer", 32'(cap.size()), 2);
    if (cap.size() == 2) chk("R7 B next", cap[0], 32'h2004);
    cap.delete();
    rd(1, 1); idle(4);
    chk("R7 completed skipped", 32'(cap.size()), 2);
    if (cap.size() == 2) chk("R7 trapping op last", cap[1], 32'hC000_000C);
    cap.delete();
    chk("R8 empty after drain", 32'(q_empty), 1);
    chk("R8 issues resume", 32'(disp_ready), 1);
    // R10 underflow
    rd(1, 1); idle(3);
    chk("R10 no data", 32'(cap.size()), 0);
    chk("R10 pulse seen", 32'(seen_under), 1);
    // R12 sequence survives drain
    chk("R12 tag kept", 32'(disp_tag), 4);
    issue(32'h3000, 32'hD000_0000);
    chk("R12 next tag", 32'(disp_tag), 0);
    idle(2);
    summary();
    $finish;
  end
endmodule